// File: doc/BRIEF.md
# Test-and-Test-and-Set Lock Requester

This block acquires and releases a spin lock in shared memory on behalf of one processor. The host pulses `acq_req` to ask for the lock and `rel_req` to give it back. `granted` stays high for as long as the lock is owned. The block reaches memory through a simple request/response port. A request is accepted in a cycle where `mem_req_valid` and `mem_req_ready` are both high. Its single response arrives on `mem_rsp_valid` in a later cycle.

While acquiring, the requester spins with plain reads and keeps memory free of write traffic while the lock is taken. Once a read shows the lock free, it tries one atomic swap that writes 1. If another agent won that swap, the requester falls back to read-spinning instead of swapping again. After each response that shows the lock taken, a fixed retry delay passes before the next read. Release is one store of 0. Several instances can share one memory port behind an arbiter, and the lock word then gives mutual exclusion among them.

Top module: `ttas_lock_agent`

## Requirements
- R1: During and after reset `granted`, `rel_err` and `mem_req_valid` are low.
- R2: The lock word is 0 when free and nonzero when taken. Operation codes on `mem_req_op` are 2'b00 read, 2'b01 swap and 2'b10 store. While the reads it issues return nonzero, an acquiring requester issues only reads and never a swap or store.
- R3: A swap is requested only after a read has returned 0, and it carries write data 1.
- R4: If a swap returns 0, `granted` rises in the cycle after the response. If it returns nonzero, `granted` stays low and the next request is a read.
- R5: A release command while `granted` is high issues one store with write data 0. `granted` falls in the cycle after the command.
- R6: A release command while `granted` is low has no effect on the lock or on memory. `rel_err` is high for exactly the following cycle.
- R7: An acquire command while `granted` is high is ignored: `granted` stays high and no memory request is issued.
- R8: At most one memory request is outstanding. A request is held unchanged until it is accepted.
- R9: After a response that shows the lock taken, the next read request is raised exactly `RETRY_GAP`+1 cycles after the response cycle.
- R10: When several requesters share one lock word, at most one is granted at any time. Each one that keeps asking is eventually granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | 1 | Acquire command pulse |
| rel_req | input | 1 | Release command pulse |
| granted | output | 1 | Lock is owned |
| rel_err | output | 1 | One-cycle pulse for a release while not owning |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_op | output | 2 | 00 read, 01 swap, 10 store |
| mem_req_addr | output | ADDR_W | Lock word address |
| mem_req_wdata | output | DATA_W | Write data for swap or store |
| mem_rsp_valid | input | 1 | Response present |
| mem_rsp_data | input | DATA_W | Old lock word (read or swap) |

## Verification
A wrong state shows up at the memory port within one request. A requester that thinks the lock is free when it is not sends a swap instead of another read. A requester that drops its pending flag raises a second request before the first response arrives. If the state believes it owns the lock when it does not, `granted` rises without a swap returning 0 in the cycle before. In a shared setup this breaks mutual exclusion on the next grant. A wrong retry counter moves the next read away from its exact cycle after a taken-lock response.

// File: rtl/ttas_lock_agent.sv
module ttas_lock_agent #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'h0040,
  parameter int RETRY_GAP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_req,
  input  logic              rel_req,
  output logic              granted,
  output logic              rel_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [1:0]        mem_req_op,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  localparam int GAP_W = (RETRY_GAP > 0) ? $clog2(RETRY_GAP + 1) : 1;
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(RETRY_GAP);
  localparam logic [1:0] OP_RD = 2'b00, OP_SW = 2'b01, OP_ST = 2'b10;

  typedef enum logic [2:0] {IDLE, READ_SPIN, SWAP, HELD, RELEASE} st_t;

  st_t             st;
  logic            pend;
  logic [GAP_W-1:0] gap;

  wire mem_state = (st == READ_SPIN) || (st == SWAP) || (st == RELEASE);
  wire rsp_ok    = mem_rsp_valid && pend;
  wire lock_free = (mem_rsp_data == '0);

  assign granted       = (st == HELD);
  assign mem_req_valid = mem_state && !pend && (gap == '0);
  assign mem_req_op    = (st == SWAP) ? OP_SW : (st == RELEASE) ? OP_ST : OP_RD;
  assign mem_req_addr  = LOCK_ADDR;
  assign mem_req_wdata = (st == SWAP) ? DATA_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      pend    <= 1'b0;
      gap     <= '0;
      rel_err <= 1'b0;
    end else begin
      rel_err <= rel_req && (st != HELD);
      if (mem_req_valid && mem_req_ready) pend <= 1'b1;
      if (gap != '0) gap <= gap - 1'b1;
      case (st)
        IDLE: if (acq_req) st <= READ_SPIN;
        READ_SPIN:
          if (rsp_ok) begin
            pend <= 1'b0;
            if (lock_free) st <= SWAP;
            else gap <= GAP_LOAD;
          end
        SWAP:
          if (rsp_ok) begin
            pend <= 1'b0;
            if (lock_free) st <= HELD;
            else begin
              st  <= READ_SPIN;
              gap <= GAP_LOAD;
            end
          end
        HELD: if (rel_req) st <= RELEASE;
        RELEASE:
          if (rsp_ok) begin
            pend <= 1'b0;
            st   <= IDLE;
          end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ttas_lock_agent_chk.sv
module ttas_lock_agent_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acq_req,
  input logic              rel_req,
  input logic              granted,
  input logic              rel_err,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [1:0]        mem_req_op,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rsp_data
);
  localparam logic [1:0] OP_RD = 2'b00, OP_SW = 2'b01, OP_ST = 2'b10;

  logic       outst, seen_free;
  logic [1:0] last_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst     <= 1'b0;
      seen_free <= 1'b0;
      last_op   <= OP_RD;
    end else begin
      if (mem_rsp_valid) outst <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        outst   <= 1'b1;
        last_op <= mem_req_op;
        if (mem_req_op == OP_SW) seen_free <= 1'b0;
      end
      if (mem_rsp_valid && outst && last_op == OP_RD)
        seen_free <= (mem_rsp_data == '0);
    end
  end

  assert_idle_in_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !granted && !rel_err && !mem_req_valid);

  assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outst);

  assert_request_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_op));

  assert_swap_after_free_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_op == OP_SW |-> seen_free && mem_req_wdata == DATA_W'(1));

  assert_store_writes_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_op == OP_ST |-> mem_req_wdata == '0);

  assert_grant_from_won_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> $past(mem_rsp_valid && outst && last_op == OP_SW && mem_rsp_data == '0));

  assert_grant_drops_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(granted) |-> $past(rel_req));

  assert_error_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |-> $past(rel_req && !granted));

  assert_no_request_when_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    granted |-> !mem_req_valid);
endmodule

bind ttas_lock_agent ttas_lock_agent_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
  .granted(granted), .rel_err(rel_err), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_op(mem_req_op),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_data(mem_rsp_data)
);

// File: tb/sim_ttas_lock_agent.sv
`timescale 1ns/1ps
module sim_ttas_lock_agent;
  localparam int N = 3;
  localparam int GAP = 3;
  localparam logic [1:0] OP_RD = 2'b00, OP_SW = 2'b01, OP_ST = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0] acq = '0, rel = '0;
  logic [N-1:0] gnt, err, rv, rdy, rspv;
  logic [1:0]   op [N];
  logic [15:0]  addr [N];
  logic [7:0]   wd [N];
  logic [7:0]   rspd [N];

  ttas_lock_agent u0 (.clk(clk), .rst_n(rst_n), .acq_req(acq[0]), .rel_req(rel[0]),
    .granted(gnt[0]), .rel_err(err[0]), .mem_req_valid(rv[0]), .mem_req_ready(rdy[0]),
    .mem_req_op(op[0]), .mem_req_addr(addr[0]), .mem_req_wdata(wd[0]),
    .mem_rsp_valid(rspv[0]), .mem_rsp_data(rspd[0]));
  ttas_lock_agent u1 (.clk(clk), .rst_n(rst_n), .acq_req(acq[1]), .rel_req(rel[1]),
    .granted(gnt[1]), .rel_err(err[1]), .mem_req_valid(rv[1]), .mem_req_ready(rdy[1]),
    .mem_req_op(op[1]), .mem_req_addr(addr[1]), .mem_req_wdata(wd[1]),
    .mem_rsp_valid(rspv[1]), .mem_rsp_data(rspd[1]));
  ttas_lock_agent u2 (.clk(clk), .rst_n(rst_n), .acq_req(acq[2]), .rel_req(rel[2]),
    .granted(gnt[2]), .rel_err(err[2]), .mem_req_valid(rv[2]), .mem_req_ready(rdy[2]),
    .mem_req_op(op[2]), .mem_req_addr(addr[2]), .mem_req_wdata(wd[2]),
    .mem_rsp_valid(rspv[2]), .mem_rsp_data(rspd[2]));

  // shared behavioural memory with round-robin arbitration
  int unsigned rr = 0;
  always_comb begin
    rdy = '0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = (rr + i) % N;
      if (rv[j] && rdy == '0) rdy[j] = 1'b1;
    end
  end

  logic [7:0] word = 8'h00;
  logic poke_en = 1'b0, steal = 1'b0;
  logic [7:0] poke_val = 8'h00;
  int nread [N], nswap [N], nstore [N];
  logic [N-1:0] outst = '0;
  logic [1:0] lastop [N];
  int proto_bad = 0;
  int cyc = 0, t_rsp = 0, gap_seen = 0;
  logic armed = 1'b0;

  initial for (int k = 0; k < N; k++) begin
    nread[k] = 0; nswap[k] = 0; nstore[k] = 0; lastop[k] = OP_RD;
  end

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    rspv <= '0;
    if (poke_en) word <= poke_val;
    for (int k = 0; k < N; k++) begin
      if (rspv[k]) outst[k] <= 1'b0;
      if (rv[k] && outst[k]) proto_bad <= proto_bad + 1;
      if (rdy[k]) begin
        outst[k]  <= 1'b1;
        lastop[k] <= op[k];
        rspv[k]   <= 1'b1;
        rr        <= (k + 1) % N;
        case (op[k])
          OP_RD: begin rspd[k] <= word; nread[k] <= nread[k] + 1; end
          OP_SW: begin
            rspd[k]  <= steal ? 8'h01 : word;
            word     <= wd[k];
            nswap[k] <= nswap[k] + 1;
          end
          default: begin rspd[k] <= 8'h00; word <= wd[k]; nstore[k] <= nstore[k] + 1; end
        endcase
      end
    end
    if (rspv[1] && lastop[1] == OP_RD && rspd[1] != 8'h00) begin
      t_rsp <= cyc; armed <= 1'b1;
    end else if (armed && rv[1]) begin
      gap_seen <= cyc - t_rsp; armed <= 1'b0;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_acq(input int k);
    acq[k] = 1'b1; tick(); acq[k] = 1'b0;
  endtask

  task automatic pulse_rel(input int k);
    rel[k] = 1'b1; tick(); rel[k] = 1'b0;
  endtask

  task automatic wait_gnt(input int k, input int lim, output logic got);
    got = 1'b0;
    for (int i = 0; i < lim && !got; i++) begin
      tick();
      got = gnt[k];
    end
  endtask

  task automatic poke(input logic [7:0] v);
    poke_val = v; poke_en = 1'b1; tick(); poke_en = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic got;
    int r0, s0, rd2;
    int grants [N];
    int hold [N];
    void'($urandom(32'd1234));
    for (int k = 0; k < N; k++) begin grants[k] = 0; hold[k] = 0; end

    tick(2);
    chk(gnt == '0 && err == '0 && rv == '0, "R1 during reset", {gnt, err, rv}, 0);
    tick(3);
    rst_n = 1'b1;
    tick();
    chk(gnt == '0 && err == '0 && rv == '0, "R1 after reset", {gnt, err, rv}, 0);

    // free lock: read 0, swap 1, granted
    pulse_acq(0);
    wait_gnt(0, 50, got);
    chk(got, "R4 agent0 granted on free lock", got, 1);
    chk(word == 8'h01 && nswap[0] == 1, "R3 one swap writing 1", nswap[0], 1);

    // acquire while held is ignored
    r0 = nread[0]; s0 = nswap[0];
    pulse_acq(0);
    tick(10);
    chk(gnt[0] && nread[0] == r0 && nswap[0] == s0, "R7 acquire in HELD ignored",
        nread[0] + nswap[0], r0 + s0);

    // second agent spins with reads only
    pulse_acq(1);
    tick(40);
    chk(nswap[1] == 0 && nstore[1] == 0, "R2 no write while lock taken", nswap[1] + nstore[1], 0);
    chk(nread[1] > 3, "R2 read spinning", nread[1], 4);
    chk(gnt[1] == 1'b0, "R10 second agent not granted", gnt[1], 0);
    chk(gap_seen == GAP + 1, "R9 retry gap", gap_seen, GAP + 1);

    // release outside HELD
    rel[1] = 1'b1; tick(); rel[1] = 1'b0;
    chk(err[1] == 1'b1, "R6 error pulse", err[1], 1);
    tick();
    chk(err[1] == 1'b0, "R6 error one cycle", err[1], 0);
    chk(gnt[0] && word == 8'h01 && nstore[1] == 0, "R6 lock untouched", word, 1);

    // release by owner, waiting agent takes over
    rel[0] = 1'b1; tick(); rel[0] = 1'b0;
    chk(gnt[0] == 1'b0, "R5 granted falls after release", gnt[0], 0);
    wait_gnt(1, 80, got);
    chk(got, "R10 waiting agent granted after release", got, 1);
    chk(nstore[0] == 1 && nswap[1] == 1, "R5 single store then swap", nstore[0], 1);

    // lost race: swap returns 1
    pulse_rel(1);
    tick(5);
    chk(word == 8'h00 && gnt == '0, "R5 store wrote 0", word, 0);
    steal = 1'b1;
    pulse_acq(2);
    for (int i = 0; i < 60 && nswap[2] == 0; i++) tick();
    steal = 1'b0;
    rd2 = nread[2];
    tick(20);
    chk(gnt[2] == 1'b0 && nswap[2] == 1, "R4 lost swap not granted", nswap[2], 1);
    chk(nread[2] > rd2, "R4 back to reading after lost swap", nread[2], rd2 + 1);
    poke(8'h00);
    wait_gnt(2, 60, got);
    chk(got && nswap[2] == 2, "R4 granted after second try", nswap[2], 2);
    pulse_rel(2);
    tick(5);

    // random traffic across three agents
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] g0;
      g0 = gnt;
      for (int k = 0; k < N; k++) begin
        acq[k] = 1'b0; rel[k] = 1'b0;
        if (gnt[k]) begin
          if (hold[k] == 0) rel[k] = 1'b1;
          else hold[k]--;
        end else if ($urandom_range(7, 0) == 0) begin
          acq[k] = 1'b1;
          hold[k] = $urandom_range(12, 0);
        end
      end
      tick();
      for (int k = 0; k < N; k++)
        if (gnt[k] && !g0[k]) begin
          grants[k]++;
          chk($countones(gnt) == 1 && word == 8'h01, "R10 exclusive grant", $countones(gnt), 1);
        end
    end
    acq = '0;
    for (int c = 0; c < 400; c++) begin
      for (int k = 0; k < N; k++) rel[k] = gnt[k];
      tick();
    end
    rel = '0;
    tick(5);
    for (int k = 0; k < N; k++)
      chk(grants[k] > 0, "R10 every agent granted", grants[k], 1);
    chk(word == 8'h00 && gnt == '0 && rv == '0, "R5 all released", word, 0);
    chk(proto_bad == 0, "R8 one outstanding request", proto_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule